// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder and Aligner

This block sits between an instruction fetch buffer and a decoder. Each cycle it looks at a window of up to five bytes that start at the current program counter, together with a count of how many of those bytes are valid. The leading byte alone sets the instruction length, which is one to five bytes. The block then reorders the opcode and operand bytes into a 32-bit instruction word and an 8-bit extension byte. The byte order depends on the format: some formats put their operand low byte first, others high byte first.

The block keeps its own program counter. Every accepted instruction leaves with the address it was fetched from, and the counter then moves on by exactly that instruction's length. The fetch side uses the count of valid bytes and the returned length to refill and shift its window. Both sides use a valid/ready handshake. A window too short for its own instruction is held off until more bytes arrive.

Top module: `insn_aligner`

## Requirements
- R1: Leading bytes 0x00–0x3F, 0x90–0xBF, 0xEB, 0xF6, 0xFE and 0xFF are one byte long. The word is that byte zero-extended, so bits 31:8 are zero.
- R2: Inside 0x80–0x8F, the four values 0x80, 0x85, 0x8A and 0x8F are two bytes long, with word = b0<<8 | b1. The other twelve values in that range are one byte long.
- R3: Leading bytes 0x40–0x7F, 0xD0–0xDB, 0xE0–0xEA and 0xF0–0xF3 are two bytes long, with word = b0<<8 | b1. Here bN is the byte at window position N, and position 0 sits in bits 7:0 of the window input.
- R4: Leading bytes 0xC0–0xCF, 0xDC–0xDF, 0xEC–0xEF and 0xF8–0xFD are three bytes long with a little-endian operand: word = b0<<16 | b2<<8 | b1.
- R5: Leading byte 0xF5 is three bytes long and packed big-endian: word = b0<<16 | b1<<8 | b2.
- R6: Leading byte 0xF7 is four bytes long: word = b0<<24 | b1<<16 | b3<<8 | b2.
- R7: Leading byte 0xF4 is five bytes long: word = b0<<24 | b1<<16 | b4<<8 | b3, and the extension byte is b2.
- R8: The extension byte is zero for every length other than five.
- R9: Each output carries the address of its first byte. The next instruction's address is the previous address plus the previous length.
- R10: A window whose valid-byte count is smaller than its decoded length is not accepted. in_ready stays low and no output appears until the count is large enough.
- R11: An accepted window appears on the outputs after the next clock edge. While out_valid is high and out_ready is low, all outputs hold their values.
- R12: After reset out_valid is low, and the first instruction's address is the parameter RESET_PC (default 0).
- R13: All 256 leading-byte values map to a length between 1 and 5. No value is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window is presented |
| in_ready | output | 1 | Window accepted this cycle when in_valid is also high |
| in_bytes | input | 40 | Five window bytes; position 0 in bits 7:0 |
| in_count | input | 3 | Number of valid bytes in the window (0–5) |
| out_valid | output | 1 | Aligned instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_word | output | 32 | Reordered instruction word |
| out_ext | output | 8 | Extension byte (five-byte format only) |
| out_len | output | 3 | Instruction length in bytes |
| out_addr | output | 16 | Address of the instruction's first byte |

## Verification
The assertions rely on two things about the fetch side. It must keep in_count no larger than five. It must also keep the window steady while it waits for in_ready: the address chain and the hold check both assume each accepted window is the next instruction in sequence. The stimulus keeps to this. A driver task holds a window until it is accepted. Each window starts at the address the scoreboard expects next. Counts are set either to the full five bytes or to exactly the decoded length. Short counts are offered only in the stall scenarios, and there the window is then completed before anything else is sent.

// File: rtl/insn_align_pkg.sv
package insn_align_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 5;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 3;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;

    // Byte layouts; each implies one length.
    typedef enum logic [2:0] {
        FMT_ONE   = 3'd0,
        FMT_TWO   = 3'd1,
        FMT_LE3   = 3'd2,
        FMT_BE3   = 3'd3,
        FMT_FOUR  = 3'd4,
        FMT_FIVE  = 3'd5
    } fmt_e;

    function automatic logic [LEN_W-1:0] fmt_len(input fmt_e f);
        case (f)
            FMT_ONE:  return LEN_W'(1);
            FMT_TWO:  return LEN_W'(2);
            FMT_LE3,
            FMT_BE3:  return LEN_W'(3);
            FMT_FOUR: return LEN_W'(4);
            FMT_FIVE: return LEN_W'(5);
            default:  return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/insn_lead_classify.sv
module insn_lead_classify
    import insn_align_pkg::*;
(
    input  logic [BYTE_W-1:0] lead,
    output fmt_e              fmt,
    output logic [LEN_W-1:0]  len
);

    // Irregular first-byte map; every value lands in exactly one arm.
    always_comb begin
        case (lead) inside
            [8'h00:8'h3F], [8'h90:8'hBF],
            8'hEB, 8'hF6, 8'hFE, 8'hFF:           fmt = FMT_ONE;
            // register-to-itself moves carry an immediate byte
            8'h80, 8'h85, 8'h8A, 8'h8F:           fmt = FMT_TWO;
            [8'h81:8'h84], [8'h86:8'h89],
            [8'h8B:8'h8E]:                        fmt = FMT_ONE;
            [8'h40:8'h7F], [8'hD0:8'hDB],
            [8'hE0:8'hEA], [8'hF0:8'hF3]:         fmt = FMT_TWO;
            [8'hC0:8'hCF], [8'hDC:8'hDF],
            [8'hEC:8'hEF], [8'hF8:8'hFD]:         fmt = FMT_LE3;
            8'hF5:                                fmt = FMT_BE3;
            8'hF7:                                fmt = FMT_FOUR;
            8'hF4:                                fmt = FMT_FIVE;
            default:                              fmt = FMT_ONE;
        endcase
        len = fmt_len(fmt);
    end

endmodule

// File: rtl/insn_byte_pack.sv
module insn_byte_pack
    import insn_align_pkg::*;
(
    input  logic [WIN_W-1:0]  window,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] ext
);

    logic [BYTE_W-1:0] b [WIN_BYTES];

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_split
        assign b[i] = window[i*BYTE_W +: BYTE_W];
    end

    localparam logic [BYTE_W-1:0] Z = '0;

    always_comb begin
        ext = Z;
        case (fmt)
            FMT_ONE:  word = {Z,    Z,    Z,    b[0]};
            FMT_TWO:  word = {Z,    Z,    b[0], b[1]};
            FMT_LE3:  word = {Z,    b[0], b[2], b[1]};
            FMT_BE3:  word = {Z,    b[0], b[1], b[2]};
            FMT_FOUR: word = {b[0], b[1], b[3], b[2]};
            FMT_FIVE: begin
                word = {b[0], b[1], b[4], b[3]};
                ext  = b[2];
            end
            default:  word = {Z, Z, Z, b[0]};
        endcase
    end

endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
    import insn_align_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WIN_W-1:0]  in_bytes,
    input  logic [LEN_W-1:0]  in_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [BYTE_W-1:0] out_ext,
    output logic [LEN_W-1:0]  out_len,
    output logic [PC_W-1:0]   out_addr
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] ext;
        logic [LEN_W-1:0]  len;
        logic [PC_W-1:0]   addr;
        logic [PC_W-1:0]   pc;
    } state_t;

    state_t st_d, st_q;

    fmt_e              cls_fmt;
    logic [LEN_W-1:0]  cls_len;
    logic [WORD_W-1:0] pk_word;
    logic [BYTE_W-1:0] pk_ext;
    logic              room, enough, fire;

    insn_lead_classify u_cls (
        .lead (in_bytes[BYTE_W-1:0]),
        .fmt  (cls_fmt),
        .len  (cls_len)
    );

    insn_byte_pack u_pack (
        .window (in_bytes),
        .fmt    (cls_fmt),
        .word   (pk_word),
        .ext    (pk_ext)
    );

    always_comb begin
        room     = !st_q.vld || out_ready;
        enough   = in_count >= cls_len;
        in_ready = room && enough;
        fire     = in_valid && in_ready;

        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (fire) begin
            st_d.vld  = 1'b1;
            st_d.word = pk_word;
            st_d.ext  = pk_ext;
            st_d.len  = cls_len;
            st_d.addr = st_q.pc;
            st_d.pc   = st_q.pc + PC_W'(cls_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;
    assign out_ext   = st_q.ext;
    assign out_len   = st_q.len;
    assign out_addr  = st_q.addr;

    // Address chain tracker used only by the checks below.
    logic              chk_seen_q;
    logic [PC_W-1:0]   chk_next_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_next_q <= RESET_PC;
        end else if (out_valid && out_ready) begin
            chk_seen_q <= 1'b1;
            chk_next_q <= out_addr + PC_W'(out_len);
        end
    end

    AST_ZERO_EXT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len == LEN_W'(1) |-> out_word[WORD_W-1:BYTE_W] == '0); // R1

    AST_EXT_ONLY_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len != LEN_W'(5) |-> out_ext == '0); // R8

    AST_ADDR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && chk_seen_q |-> out_addr == chk_next_q); // R9

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !chk_seen_q |-> out_addr == RESET_PC); // R12

    AST_WINDOW_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_len <= $past(in_count)); // R10

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ext)
            && $stable(out_len) && $stable(out_addr)); // R11

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len >= LEN_W'(1) && out_len <= LEN_W'(5)); // R13

endmodule

// File: tb/insn_aligner_bench.sv
module insn_aligner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_bytes = '0;
    logic [2:0]  in_count = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic [7:0]  out_ext;
    logic [2:0]  out_len;
    logic [15:0] out_addr;

    always #4 clk = ~clk; // 125 MHz

    insn_aligner u_insn_aligner (
        .clk, .rst_n, .in_valid, .in_ready, .in_bytes, .in_count,
        .out_valid, .out_ready, .out_word, .out_ext, .out_len, .out_addr
    );

    typedef struct {
        logic [31:0] word;
        logic [7:0]  ext;
        logic [2:0]  len;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    logic [15:0] tb_pc = 16'h0000; // R12: first address is RESET_PC = 0
    logic [31:0] rng = 32'h1234_5678;
    logic [15:0] bp_lfsr = 16'hACE1;
    bit          bp_on = 1'b0;
    bit          bp_block = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected decode, written from the requirement list.
    function automatic void ref_decode(input logic [39:0] w, output logic [2:0] n,
                                       output logic [31:0] wd, output logic [7:0] x,
                                       output string tag);
        logic [7:0] c0 = w[7:0];
        logic [7:0] c1 = w[15:8];
        logic [7:0] c2 = w[23:16];
        logic [7:0] c3 = w[31:24];
        logic [7:0] c4 = w[39:32];
        x = 8'h00;
        if (c0 == 8'hF4) begin
            n = 5; wd = {c0, c1, c4, c3}; x = c2; tag = "R7";
        end else if (c0 == 8'hF7) begin
            n = 4; wd = {c0, c1, c3, c2}; tag = "R6";
        end else if (c0 == 8'hF5) begin
            n = 3; wd = {8'h00, c0, c1, c2}; tag = "R5";
        end else if ((c0 >= 8'hC0 && c0 <= 8'hCF) || (c0 >= 8'hDC && c0 <= 8'hDF) ||
                     (c0 >= 8'hEC && c0 <= 8'hEF) || (c0 >= 8'hF8 && c0 <= 8'hFD)) begin
            n = 3; wd = {8'h00, c0, c2, c1}; tag = "R4";
        end else if (c0 == 8'h80 || c0 == 8'h85 || c0 == 8'h8A || c0 == 8'h8F) begin
            n = 2; wd = {16'h0000, c0, c1}; tag = "R2";
        end else if ((c0 >= 8'h40 && c0 <= 8'h7F) || (c0 >= 8'hD0 && c0 <= 8'hDB) ||
                     (c0 >= 8'hE0 && c0 <= 8'hEA) || (c0 >= 8'hF0 && c0 <= 8'hF3)) begin
            n = 2; wd = {16'h0000, c0, c1}; tag = "R3";
        end else if (c0 >= 8'h80 && c0 <= 8'h8F) begin
            n = 1; wd = {24'h0, c0}; tag = "R2";
        end else begin
            n = 1; wd = {24'h0, c0}; tag = "R1";
        end
    endfunction

    function automatic logic [39:0] make_win(input logic [7:0] lead);
        rng = rng * 32'd1664525 + 32'd1013904223;
        make_win = {rng[31:0], lead};
    endfunction

    // Driver: holds the window until taken, then files the expectation.
    task automatic send(input logic [39:0] win, input logic [2:0] cnt);
        exp_t it;
        ref_decode(win, it.len, it.word, it.ext, it.tag);
        it.addr = tb_pc;
        @(negedge clk);
        in_bytes = win;
        in_count = cnt;
        in_valid = 1'b1;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        sb.push_back(it);
        tb_pc = tb_pc + 16'(it.len);
        @(posedge clk);
        #1;
        chk(out_valid == 1'b1, "R11", "valid one cycle after accept", 64'(out_valid), 64'd1);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || out_valid) @(negedge clk);
    endtask

    // Monitor: picks out_ready, then pops and compares at the handshake.
    always @(negedge clk) begin
        bp_lfsr   = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
        out_ready = bp_block ? 1'b0 : (bp_on ? bp_lfsr[0] : 1'b1);
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected output", 64'(out_word), 64'd0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(out_word == it.word, it.tag, "word", 64'(out_word), 64'(it.word));
                chk(out_len == it.len, "R13", "length", 64'(out_len), 64'(it.len));
                chk(out_ext == it.ext, (it.len == 3'd5) ? "R7" : "R8", "ext",
                    64'(out_ext), 64'(it.ext));
                chk(out_addr == it.addr, "R9", "address", 64'(out_addr), 64'(it.addr));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R11", "watchdog expired", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] w;
        logic [2:0]  n;
        logic [31:0] wd;
        logic [7:0]  x;
        logic [31:0] held;
        string       tg;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);

        // R13: all leading bytes with a full window
        for (int b = 0; b < 256; b++) send(make_win(8'(b)), 3'd5);
        drain();

        // Boundary count equal to length, with random back-pressure (R10, R11)
        bp_on = 1'b1;
        for (int b = 255; b >= 0; b--) begin
            w = make_win(8'(b));
            ref_decode(w, n, wd, x, tg);
            send(w, n);
        end
        drain();
        bp_on = 1'b0;

        // R10: short windows are held off
        w = make_win(8'hF4);
        @(negedge clk);
        in_bytes = w; in_count = 3'd4; in_valid = 1'b1;
        #2;
        chk(in_ready == 1'b0, "R10", "ready with 4 of 5 bytes", 64'(in_ready), 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            chk(in_ready == 1'b0, "R10", "ready while short", 64'(in_ready), 64'd0);
            chk(out_valid == 1'b0, "R10", "output while short", 64'(out_valid), 64'd0);
        end
        in_valid = 1'b0;
        send(w, 3'd5);
        drain();

        w = make_win(8'h8A);
        @(negedge clk);
        in_bytes = w; in_count = 3'd1; in_valid = 1'b1;
        #2;
        chk(in_ready == 1'b0, "R10", "2-byte move with 1 byte", 64'(in_ready), 64'd0);
        in_count = 3'd0;
        #1;
        chk(in_ready == 1'b0, "R10", "empty window", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        send(w, 3'd2);
        drain();

        // R11: hold under back-pressure
        bp_block = 1'b1;
        send(make_win(8'hF7), 3'd5);
        @(negedge clk);
        #2;
        held = out_word;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            chk(out_valid == 1'b1, "R11", "valid held", 64'(out_valid), 64'd1);
            chk(out_word == held, "R11", "word held", 64'(out_word), 64'(held));
        end
        w = make_win(8'h10);
        @(negedge clk);
        in_bytes = w; in_count = 3'd5; in_valid = 1'b1;
        #2;
        chk(in_ready == 1'b0, "R11", "ready while output blocked", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        bp_block = 1'b0;
        send(w, 3'd5);
        drain();

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule